// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does a hardware walk of a two-level page structure held in memory. On a request it latches the virtual address and the access type. It then reads the directory entry, which is located from the directory base register. Next it reads the table entry that the directory entry points to. At the end it reports either a physical address or a fault with a reason code.

Each walk issues at most two reads on a simple read port. The port takes a one-cycle request strobe and returns data with a valid strobe after any latency. The low twelve bits of the final entry are returned unchanged, so that a translation cache can be filled from the same result. Only one walk is in flight at a time. A new request is accepted only when the walker is idle.

Top module: `page_walker`

## Requirements
- R1: After reset, done_o, fault_o, mem_req_o and busy_o are all low.
- R2: The first read goes to address {dir_base_i[31:12], vaddr[31:22], 2'b00}. Bits 11:0 of dir_base_i have no effect.
- R3: The second read goes to address {dir_entry[31:12], vaddr[21:12], 2'b00}. It is issued only after the first read has returned.
- R4: On success, paddr_o = {tbl_entry[31:12], vaddr[11:0]}, leaf_attr_o = tbl_entry[11:0] and fault_o is low while done_o is high.
- R5: A directory entry with bit 0 (present) clear ends the walk with fault_o high and fault_code_o = 1. Only one read is made.
- R6: A table entry with bit 0 (present) clear ends the walk with fault_o high and fault_code_o = 2.
- R7: A write request (write_i = 1) ends with fault_code_o = 3 when either entry has bit 1 (read/write) clear. After a present directory entry with bit 1 clear, no second read is made. A read request through the same entries succeeds.
- R8: A directory entry whose frame is the directory itself is followed like any other entry. The directory is then read as a table.
- R9: req_i while busy_o is high is ignored. The running walk ends with the result for the first address, and no extra walk follows.
- R10: done_o and each mem_req_o pulse last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a walk (taken when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | Access is a write |
| dir_base_i | input | 32 | Directory base; bits 31:12 used |
| mem_req_o | output | 1 | Read strobe, one cycle per read |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk finished with a fault |
| fault_code_o | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 write protect |
| paddr_o | output | 32 | Translated physical address |
| leaf_attr_o | output | 12 | Low twelve bits of the table entry |

## Verification
The bench builds the walker with its default widths: 32-bit addresses, 10-bit indices and 12-bit offsets. This makes the directory index, the table index and the frame fields exactly as wide as the byte addresses a small memory model can serve. The directory sits at a nonzero frame and the table at frame zero, with noise placed in the low bits of the base. As a result, a walker that drops the base, swaps the index fields or ignores a level's entry lands on the wrong word. The 2-cycle read latency of the model exposes any second read issued before the first returns. It also gives room to inject a stray request in the middle of a walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_WAIT_PDE, ST_READ_PTE, ST_WAIT_PTE, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_TBL  = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned RW_BIT      = 1;
endpackage

// File: rtl/pw_entry_chk.sv
module pw_entry_chk
  import pw_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic             write_i,
  input  logic             tbl_lvl_i,
  output logic             ok_o,
  output fault_e           code_o
);
  always_comb begin
    if (!entry_i[PRESENT_BIT])                 code_o = tbl_lvl_i ? FLT_TBL : FLT_DIR;
    else if (write_i && !entry_i[RW_BIT])      code_o = FLT_PROT;
    else                                       code_o = FLT_NONE;
  end
  assign ok_o = (code_o == FLT_NONE);

  always_comb begin
    if (ok_o) assert_ok_present_R5: assert (entry_i[PRESENT_BIT]);
  end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]       dir_base_i,
  input  logic [ADDR_W-1:0]       vaddr_i,
  input  logic [ADDR_W-OFF_W-1:0] tbl_frame_i,
  input  logic                    tbl_phase_i,
  output logic [ADDR_W-1:0]       mem_addr_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned TBL_LSB = OFF_W;
  localparam int unsigned DIR_LSB = OFF_W + IDX_W;
  localparam int unsigned PAD_W   = OFF_W - IDX_W;

  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx;

  assign frame = tbl_phase_i ? tbl_frame_i : dir_base_i[ADDR_W-1:OFF_W];
  assign idx   = tbl_phase_i ? vaddr_i[TBL_LSB +: IDX_W] : vaddr_i[DIR_LSB +: IDX_W];
  assign mem_addr_o = {frame, idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       vaddr_i,
  input  logic                    write_i,
  input  logic                    mem_valid_i,
  input  logic [ADDR_W-1:0]       mem_rdata_i,
  input  logic                    chk_ok_i,
  input  fault_e                  chk_code_i,
  output logic [ADDR_W-1:0]       va_q_o,
  output logic                    wr_q_o,
  output logic [ADDR_W-OFF_W-1:0] tbl_frame_o,
  output logic                    tbl_phase_o,
  output logic                    mem_req_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fault_o,
  output fault_e                  fault_code_o,
  output logic [ADDR_W-1:0]       paddr_o,
  output logic [OFF_W-1:0]        leaf_attr_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  walk_state_e state_q, state_d;
  logic [FRAME_W-1:0] frame_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = ST_READ_PDE;
      ST_READ_PDE: state_d = ST_WAIT_PDE;
      ST_WAIT_PDE: if (mem_valid_i) state_d = chk_ok_i ? ST_READ_PTE : ST_FAULT;
      ST_READ_PTE: state_d = ST_WAIT_PTE;
      ST_WAIT_PTE: if (mem_valid_i) state_d = chk_ok_i ? ST_DONE : ST_FAULT;
      ST_DONE:     state_d = ST_IDLE;
      ST_FAULT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      va_q_o       <= '0;
      wr_q_o       <= 1'b0;
      frame_q      <= '0;
      fault_code_o <= FLT_NONE;
      paddr_o      <= '0;
      leaf_attr_o  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        va_q_o       <= vaddr_i;
        wr_q_o       <= write_i;
        fault_code_o <= FLT_NONE;
      end
      if (mem_valid_i && (state_q == ST_WAIT_PDE || state_q == ST_WAIT_PTE)) begin
        fault_code_o <= chk_code_i;
        if (state_q == ST_WAIT_PDE) frame_q <= mem_rdata_i[ADDR_W-1:OFF_W];
        else if (chk_ok_i) begin
          paddr_o     <= {mem_rdata_i[ADDR_W-1:OFF_W], va_q_o[OFF_W-1:0]};
          leaf_attr_o <= mem_rdata_i[OFF_W-1:0];
        end
      end
    end
  end

  assign tbl_frame_o = frame_q;
  assign tbl_phase_o = (state_q == ST_READ_PTE);
  assign mem_req_o   = (state_q == ST_READ_PDE) || (state_q == ST_READ_PTE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault_o     = (state_q == ST_FAULT);

  assert_req_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fault_coded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_code_o != FLT_NONE);
  assert_va_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(va_q_o) && $stable(wr_q_o));
  assert_pte_after_pde_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_PDE && !mem_valid_i) |=> !mem_req_o);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [OFF_W-1:0]  leaf_attr_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] tbl_frame;
  logic               tbl_phase;
  logic               chk_ok;
  fault_e             chk_code;
  fault_e             code_q;

  pw_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .vaddr_i, .write_i, .mem_valid_i, .mem_rdata_i,
    .chk_ok_i(chk_ok), .chk_code_i(chk_code),
    .va_q_o(va_q), .wr_q_o(wr_q), .tbl_frame_o(tbl_frame), .tbl_phase_o(tbl_phase),
    .mem_req_o, .busy_o, .done_o, .fault_o, .fault_code_o(code_q),
    .paddr_o, .leaf_attr_o
  );

  pw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .dir_base_i, .vaddr_i(va_q), .tbl_frame_i(tbl_frame), .tbl_phase_i(tbl_phase),
    .mem_addr_o
  );

  pw_entry_chk #(.ENT_W(ADDR_W)) u_chk (
    .entry_i(mem_rdata_i), .write_i(wr_q), .tbl_lvl_i(busy_o && !tbl_phase && tbl_level_wait()),
    .ok_o(chk_ok), .code_o(chk_code)
  );

  function automatic logic tbl_level_wait();
    return (u_ctrl.state_q == ST_WAIT_PTE);
  endfunction

  assign fault_code_o = code_q;

  assert_req_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_done_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> fault_code_o == 2'd0);
endmodule

// File: tb/page_walker_bench.sv
`timescale 1ns/1ps
module page_walker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        write_i = 1'b0;
  logic [31:0] dir_base_i = 32'h0000_1ABC;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o, fault_o;
  logic [1:0]  fault_code_o;
  logic [31:0] paddr_o;
  logic [11:0] leaf_attr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  page_walker u_page_walker (
    .clk_i, .rst_ni, .req_i, .vaddr_i, .write_i, .dir_base_i,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_rdata_i,
    .busy_o, .done_o, .fault_o, .fault_code_o, .paddr_o, .leaf_attr_o
  );

  // 8 KiB memory: table at frame 0, directory at frame 1
  logic [31:0] mem [0:2047];
  logic [31:0] rd_addr [0:3];
  int          n_reads = 0;
  int          lat = 0;
  logic [31:0] pend_addr;

  always @(posedge clk_i) begin
    mem_valid_i <= 1'b0;
    if (mem_req_o) begin
      if (n_reads < 4) rd_addr[n_reads] <= mem_addr_o;
      n_reads   <= n_reads + 1;
      pend_addr <= mem_addr_o;
      lat       <= 2;
    end else if (lat == 1) begin
      mem_valid_i <= 1'b1;
      mem_rdata_i <= mem[pend_addr[12:2]];
      lat         <= 0;
    end else if (lat > 1) lat <= lat - 1;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        flt;
    logic [1:0]  code;
    logic [31:0] pa;
    logic [11:0] attr;
    logic [2:0]  reads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_5123, 1'b0, 1'b0, 2'd0, 32'hABCD_E123, 12'h003, 3'd2},
    '{32'h0000_5123, 1'b1, 1'b0, 2'd0, 32'hABCD_E123, 12'h003, 3'd2},
    '{32'h0000_6456, 1'b0, 1'b0, 2'd0, 32'h1234_5456, 12'h001, 3'd2},
    '{32'h0000_6456, 1'b1, 1'b1, 2'd3, 32'h0,        12'h0,   3'd2},
    '{32'h0000_7000, 1'b0, 1'b1, 2'd2, 32'h0,        12'h0,   3'd2},
    '{32'h0080_0000, 1'b0, 1'b1, 2'd1, 32'h0,        12'h0,   3'd1},
    '{32'h00C0_5000, 1'b0, 1'b0, 2'd0, 32'hABCD_E000, 12'h003, 3'd2},
    '{32'h00C0_5000, 1'b1, 1'b1, 2'd3, 32'h0,        12'h0,   3'd1},
    '{32'h0040_0ABC, 1'b0, 1'b0, 2'd0, 32'h0000_0ABC, 12'h003, 3'd2},
    '{32'h003F_FFFF, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF, 12'h063, 3'd2}
  };

  bit timed_out = 0;

  task automatic walk(input logic [31:0] va, input logic wr, input bool_stray, output int cyc);
    @(negedge clk_i);
    n_reads = 0;
    vaddr_i = va; write_i = wr; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; vaddr_i = 32'hDEAD_BEEF; write_i = 1'b1;
    cyc = 0;
    while (!done_o && cyc < 100) begin
      if (bool_stray && cyc == 2) req_i = 1'b1;
      else req_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    req_i = 1'b0;
    if (cyc >= 100) begin
      timed_out = 1;
      check("R10", "walk timeout", 32'd1, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[1024 + 0] = 32'h0000_0003;   // dir[0] -> table frame 0, rw
    mem[1024 + 1] = 32'h0000_1001;   // dir[1] -> directory itself
    mem[1024 + 2] = 32'h0000_0000;   // dir[2] absent
    mem[1024 + 3] = 32'h0000_0001;   // dir[3] -> table, read-only
    mem[5]     = 32'hABCD_E003;
    mem[6]     = 32'h1234_5001;
    mem[7]     = 32'h0000_0000;
    mem[1023]  = 32'hFFFF_F063;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "done_o", {31'b0, done_o}, 32'd0);
    check("R1", "fault_o", {31'b0, fault_o}, 32'd0);
    check("R1", "mem_req_o", {31'b0, mem_req_o}, 32'd0);
    check("R1", "busy_o", {31'b0, busy_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      int cyc;
      logic [31:0] exp_pde;
      walk(VECS[v].va, VECS[v].wr, 1'b0, cyc);
      exp_pde = {dir_base_i[31:12], VECS[v].va[31:22], 2'b00};
      check("R5", "fault_o", {31'b0, fault_o}, {31'b0, VECS[v].flt});
      check("R6", "fault_code_o", {30'b0, fault_code_o}, {30'b0, VECS[v].code});
      check("R7", "read count", n_reads, {29'b0, VECS[v].reads});
      check("R2", "directory read addr", rd_addr[0], exp_pde);
      if (VECS[v].reads == 3'd2)
        check("R3", "table read addr", rd_addr[1],
              {mem[exp_pde[12:2]][31:12], VECS[v].va[21:12], 2'b00});
      if (!VECS[v].flt) begin
        check(v == 8 ? "R8" : "R4", "paddr_o", paddr_o, VECS[v].pa);
        check("R4", "leaf_attr_o", {20'b0, leaf_attr_o}, {20'b0, VECS[v].attr});
      end
      @(negedge clk_i);
      check("R10", "done_o one cycle", {31'b0, done_o}, 32'd0);
    end

    // R9: stray request during a walk is ignored
    begin
      int cyc;
      walk(32'h0000_6456, 1'b0, 1'b1, cyc);
      check("R9", "paddr under stray req", paddr_o, 32'h1234_5456);
      check("R9", "no fault under stray req", {31'b0, fault_o}, 32'd0);
      repeat (6) @(negedge clk_i);
      check("R9", "no extra walk (reads)", n_reads, 32'd2);
      check("R9", "idle after walk", {31'b0, busy_o}, 32'd0);
    end

    // R2: low base bits ignored
    begin
      int cyc;
      dir_base_i = 32'h0000_1000;
      walk(32'h0000_5123, 1'b0, 1'b0, cyc);
      check("R2", "clean base paddr", paddr_o, 32'hABCD_E123);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule